// File: doc/BRIEF.md
# Smooth Pulse-Masking Clock Trimmer

This block sits between a slow reference clock (typically 32.768 kHz) and the prescaler chain of a calendar. Each cycle of the reference clock it reports how many prescaler ticks that cycle is worth: zero when the cycle is masked, one normally, two when an extra pulse is inserted. Over a fixed trim window of 2^WIN_LOG cycles (2^20 by default, about 32 s) it removes a programmed number of pulses and can add a fixed block of 2^MINUS_W pulses (512 by default). The net correction per window is therefore +512·plus − minus, in steps of about 0.954 ppm, spanning roughly ±488 ppm.

Masked pulses are spread across the window, not taken in one burst. The window is cut into 2^MINUS_W slots of equal length. The last cycle of a slot is masked when the bit-reversed slot index is below the programmed count. Inserted pulses fall on the first cycle of every slot. A new setting is staged by a one-cycle write strobe. It stays pending until the next window boundary, when it becomes active. Writes that arrive while a setting is pending are dropped.

The control is a four-state machine. State BYPASS means the active setting is zero with plus clear. State TRIM means a non-zero correction is active. BYPASS_PEND and TRIM_PEND are the same two states with a staged setting waiting. The transitions are: write (BYPASS→BYPASS_PEND, TRIM→TRIM_PEND). At a boundary, commit-to-zero (either pending state→BYPASS) or commit-to-trim (either pending state→TRIM).

Top module: `smooth_calib`

## Requirements
- R1: While reset is asserted, tick_cnt is 1, cfg_pending is 0 and win_last is 0.
- R2: win_last is high for exactly one cycle in every 2^WIN_LOG cycles. After reset release, the first cycle counts as window position 0, and win_last marks position 2^WIN_LOG−1.
- R3: With an active count of 0 and plus clear, tick_cnt is 1 on every cycle.
- R4: In every window, the number of cycles with tick_cnt = 0 equals the active count (0..2^MINUS_W−1).
- R5: Position p is masked (tick_cnt = 0) exactly when its low WIN_LOG−MINUS_W bits are all ones and the bit reversal of the slot index p[WIN_LOG−1:WIN_LOG−MINUS_W] is below the active count.
- R6: With plus active, tick_cnt = 2 exactly at positions whose low WIN_LOG−MINUS_W bits are zero, giving 2^MINUS_W inserted pulses per window. With plus clear, tick_cnt is never 2.
- R7: A setting accepted during window w becomes active at the start of window w+1. If it is accepted on the last cycle of a window, it becomes active at the start of window w+2. The active setting never changes elsewhere.
- R8: cfg_pending rises in the cycle after an accepted write and stays high through the last cycle of the window before activation. It is low in the first cycle of the new window.
- R9: A write while cfg_pending is high has no effect on any later window.
- R10: tick_cnt only takes the values 0, 1 and 2. A mask and an insertion never fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle write strobe for a new setting |
| cfg_plus | input | 1 | Write data: add 2^MINUS_W pulses per window |
| cfg_minus | input | MINUS_W | Write data: pulses to remove per window |
| tick_cnt | output | 2 | Prescaler ticks this cycle: 0 masked, 1 normal, 2 inserted |
| cfg_pending | output | 1 | A staged setting waits for the next boundary |
| win_last | output | 1 | Last cycle of the current trim window |

## Verification
The trimmer is run with bypass, with masking alone at counts of 1, 256 and 511, with insertion alone, and with insertion combined with a count of 300. Each window's tick pattern is compared cycle by cycle against the slot and bit-reversal rule. A count of 1 shows whether the first slot is chosen. A count of 256 shows whether masks fall on alternate slots. A count of 511 exposes off-by-one errors at the top of the range. The combined case shows that masks and insertions use separate cycles. A second write while the first is pending, and a write on the last cycle of a window, separate correct staging from staging that is one window early or late.

// File: rtl/calib_pkg.sv
package calib_pkg;

    // Control states of the trim configuration machine
    typedef enum logic [1:0] {
        ST_BYPASS      = 2'd0,
        ST_BYPASS_PEND = 2'd1,
        ST_TRIM        = 2'd2,
        ST_TRIM_PEND   = 2'd3
    } cal_state_e;

    // Ticks reported to the prescaler each reference cycle
    localparam logic [1:0] TICK_DROP = 2'd0;
    localparam logic [1:0] TICK_ONE  = 2'd1;
    localparam logic [1:0] TICK_TWO  = 2'd2;

endpackage

// File: rtl/calib_win_ctr.sv
module calib_win_ctr #(
    parameter int WIN_LOG = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [WIN_LOG-1:0] pos,
    output logic               win_last
);

    localparam logic [WIN_LOG-1:0] POS_LAST = {WIN_LOG{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    assign win_last = rst_n && (pos == POS_LAST);

endmodule

// File: rtl/calib_cfg_fsm.sv
module calib_cfg_fsm
    import calib_pkg::*;
#(
    parameter int MINUS_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_last,
    input  logic               cfg_wr,
    input  logic               cfg_plus,
    input  logic [MINUS_W-1:0] cfg_minus,
    output logic               act_plus,
    output logic [MINUS_W-1:0] act_minus,
    output logic               cfg_pending
);

    cal_state_e         state_q, state_d;
    logic               stg_plus;
    logic [MINUS_W-1:0] stg_minus;
    logic               stg_zero;

    assign stg_zero = !stg_plus && (stg_minus == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: begin
                if (cfg_wr) state_d = ST_BYPASS_PEND;
            end
            ST_TRIM: begin
                if (cfg_wr) state_d = ST_TRIM_PEND;
            end
            ST_BYPASS_PEND, ST_TRIM_PEND: begin
                if (win_last) state_d = stg_zero ? ST_BYPASS : ST_TRIM;
            end
            default: state_d = ST_BYPASS;
        endcase
    end

    // Output registers: staged and active settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_plus  <= 1'b0;
            stg_minus <= '0;
            act_plus  <= 1'b0;
            act_minus <= '0;
        end else begin
            unique case (state_q)
                ST_BYPASS, ST_TRIM: begin
                    if (cfg_wr) begin
                        stg_plus  <= cfg_plus;
                        stg_minus <= cfg_minus;
                    end
                end
                ST_BYPASS_PEND, ST_TRIM_PEND: begin
                    if (win_last) begin
                        act_plus  <= stg_plus;
                        act_minus <= stg_minus;
                    end
                end
                default: begin
                    act_plus  <= 1'b0;
                    act_minus <= '0;
                end
            endcase
        end
    end

    assign cfg_pending = (state_q == ST_BYPASS_PEND) || (state_q == ST_TRIM_PEND);

endmodule

// File: rtl/calib_pulse_gen.sv
module calib_pulse_gen
    import calib_pkg::*;
#(
    parameter int WIN_LOG = 20,
    parameter int MINUS_W = 9
) (
    input  logic               rst_n,
    input  logic [WIN_LOG-1:0] pos,
    input  logic               act_plus,
    input  logic [MINUS_W-1:0] act_minus,
    output logic [1:0]         tick_cnt
);

    localparam int SLOT_LOG = WIN_LOG - MINUS_W;

    logic [MINUS_W-1:0]  slot;
    logic [MINUS_W-1:0]  slot_rev;
    logic [SLOT_LOG-1:0] sub;
    logic                mask_hit;
    logic                ins_hit;

    assign slot = pos[WIN_LOG-1:SLOT_LOG];
    assign sub  = pos[SLOT_LOG-1:0];

    // Bit-reversed slot index spreads the masked slots over the window
    for (genvar i = 0; i < MINUS_W; i++) begin : g_rev
        assign slot_rev[i] = slot[MINUS_W-1-i];
    end

    assign mask_hit = (sub == {SLOT_LOG{1'b1}}) && (slot_rev < act_minus);
    assign ins_hit  = act_plus && (sub == '0);

    always_comb begin
        if (!rst_n)        tick_cnt = TICK_ONE;
        else if (mask_hit) tick_cnt = TICK_DROP;
        else if (ins_hit)  tick_cnt = TICK_TWO;
        else               tick_cnt = TICK_ONE;
    end

endmodule

// File: rtl/smooth_calib.sv
module smooth_calib #(
    parameter int WIN_LOG = 20,
    parameter int MINUS_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_plus,
    input  logic [MINUS_W-1:0] cfg_minus,
    output logic [1:0]         tick_cnt,
    output logic               cfg_pending,
    output logic               win_last
);

    logic [WIN_LOG-1:0] pos;
    logic               act_plus;
    logic [MINUS_W-1:0] act_minus;

    calib_win_ctr #(.WIN_LOG(WIN_LOG)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .win_last (win_last)
    );

    calib_cfg_fsm #(.MINUS_W(MINUS_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_last    (win_last),
        .cfg_wr      (cfg_wr),
        .cfg_plus    (cfg_plus),
        .cfg_minus   (cfg_minus),
        .act_plus    (act_plus),
        .act_minus   (act_minus),
        .cfg_pending (cfg_pending)
    );

    calib_pulse_gen #(.WIN_LOG(WIN_LOG), .MINUS_W(MINUS_W)) u_gen (
        .rst_n     (rst_n),
        .pos       (pos),
        .act_plus  (act_plus),
        .act_minus (act_minus),
        .tick_cnt  (tick_cnt)
    );

endmodule

// File: rtl/calib_chk.sv
module calib_chk #(
    parameter int WIN_LOG = 20,
    parameter int MINUS_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic               cfg_pending,
    input logic               win_last,
    input logic [1:0]         tick_cnt,
    input logic               act_plus,
    input logic [MINUS_W-1:0] act_minus
);

    logic [WIN_LOG-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= '0;
        else        seen <= seen + 1'b1;
    end

    // R10
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt != 2'd3);

    // R2
    win_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |-> (seen == {WIN_LOG{1'b1}}));

    // R8
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_pending) |=> cfg_pending);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pending && !win_last) |=> cfg_pending);

    // R8
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pending && win_last) |=> !cfg_pending);

    // R7
    act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_last |=> ($stable(act_minus) && $stable(act_plus)));

    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_plus && act_minus == '0) |-> (tick_cnt == 2'd1));

    // R6
    insert_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_cnt == 2'd2) |-> act_plus);

endmodule

bind smooth_calib calib_chk #(.WIN_LOG(WIN_LOG), .MINUS_W(MINUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_pending (cfg_pending),
    .win_last    (win_last),
    .tick_cnt    (tick_cnt),
    .act_plus    (act_plus),
    .act_minus   (act_minus)
);

// File: tb/smooth_calib_tb.sv
module smooth_calib_tb;

    localparam int CLK_P    = 10;
    localparam int WIN_LOG  = 12;
    localparam int MINUS_W  = 9;
    localparam int WIN      = 1 << WIN_LOG;
    localparam int SLOT_LOG = WIN_LOG - MINUS_W;
    localparam int SUB_MAX  = (1 << SLOT_LOG) - 1;

    typedef struct {
        int   win;
        logic plus;
        int   minus;
    } item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr = 1'b0;
    logic               cfg_plus = 1'b0;
    logic [MINUS_W-1:0] cfg_minus = '0;
    logic [1:0]         tick_cnt;
    logic               cfg_pending;
    logic               win_last;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    n = 0;
    bit    run = 1'b0;
    logic  m_plus = 1'b0;
    int    m_minus = 0;
    int    c_mask, c_ins, c_bad3, c_pat, c_pend, c_wl, c_non1;

    always #(CLK_P/2) clk = ~clk;

    smooth_calib #(.WIN_LOG(WIN_LOG), .MINUS_W(MINUS_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_plus    (cfg_plus),
        .cfg_minus   (cfg_minus),
        .tick_cnt    (tick_cnt),
        .cfg_pending (cfg_pending),
        .win_last    (win_last)
    );

    function automatic int rev_bits(input int v);
        int r = 0;
        for (int i = 0; i < MINUS_W; i++) begin
            if (v[i]) r = r | (1 << (MINUS_W - 1 - i));
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic void clear_counts();
        c_mask = 0; c_ins = 0; c_bad3 = 0; c_pat = 0;
        c_pend = 0; c_wl = 0; c_non1 = 0;
    endfunction

    // Monitor: pops staged items at window starts, compares each cycle
    always @(negedge clk) begin
        if (run) begin
            int p, w, sub, e_tick;
            bit e_mask, e_ins;
            n++;
            p = n % WIN;
            w = n / WIN;
            if (p == 0) begin
                clear_counts();
                if (q.size() > 0 && q[0].win == w) begin
                    m_plus  = q[0].plus;
                    m_minus = q[0].minus;
                    void'(q.pop_front());
                end
            end
            sub    = p & SUB_MAX;
            e_mask = (sub == SUB_MAX) && (rev_bits(p >> SLOT_LOG) < m_minus);
            e_ins  = m_plus && (sub == 0);
            e_tick = e_mask ? 0 : (e_ins ? 2 : 1);
            if (tick_cnt == 2'd0) c_mask++;
            if (tick_cnt == 2'd2) c_ins++;
            if (tick_cnt == 2'd3) c_bad3++;
            if (tick_cnt != 2'd1) c_non1++;
            if (int'(tick_cnt) != e_tick) c_pat++;
            if (cfg_pending != (q.size() != 0)) c_pend++;
            if (win_last != (p == WIN - 1)) c_wl++;
            if (p == WIN - 1) begin
                check(c_mask == m_minus, "R4 masked per window", c_mask, m_minus);
                check(c_ins == (m_plus ? (1 << MINUS_W) : 0), "R6 inserted per window",
                      c_ins, m_plus ? (1 << MINUS_W) : 0);
                check(c_pat == 0, "R5 R7 tick pattern mismatches", c_pat, 0);
                check(c_pend == 0, "R8 pending mismatches", c_pend, 0);
                check(c_wl == 0, "R2 win_last mismatches", c_wl, 0);
                check(c_bad3 == 0, "R10 illegal tick values", c_bad3, 0);
                if (!m_plus && m_minus == 0)
                    check(c_non1 == 0, "R3 bypass non-unit ticks", c_non1, 0);
                if (w == 4)
                    check(c_mask == 100, "R9 ignored write kept first count", c_mask, 100);
            end
        end
    end

    task automatic wait_pos(input int wt, input int pt);
        do begin
            @(negedge clk);
            #(CLK_P/4);
        end while (!((n / WIN) == wt && (n % WIN) == pt));
    endtask

    // Driver: writes a setting, predicts its activation window
    task automatic write_cfg(input logic plus, input int minus);
        int p, w;
        p = n % WIN;
        w = n / WIN;
        cfg_wr    = 1'b1;
        cfg_plus  = plus;
        cfg_minus = MINUS_W'(minus);
        if (q.size() == 0) begin
            item_t it;
            it.win   = w + ((p == WIN - 1) ? 2 : 1);
            it.plus  = plus;
            it.minus = minus;
            q.push_back(it);
        end
        @(negedge clk);
        #(CLK_P/4);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        clear_counts();
        repeat (3) @(negedge clk);
        check(tick_cnt == 2'd1, "R1 reset tick", tick_cnt, 1);
        check(cfg_pending == 1'b0, "R1 reset pending", cfg_pending, 0);
        check(win_last == 1'b0, "R1 reset win_last", win_last, 0);
        #(CLK_P/4);
        rst_n = 1'b1;
        run   = 1'b1;
        wait_pos(0, 100);  write_cfg(1'b0, 1);     // R5 single mask
        wait_pos(1, 100);  write_cfg(1'b0, 256);   // R5 alternate slots
        wait_pos(2, 100);  write_cfg(1'b0, 511);   // R4 top of range
        wait_pos(3, 100);  write_cfg(1'b0, 100);
        wait_pos(3, 200);  write_cfg(1'b0, 5);     // R9 dropped
        wait_pos(4, 100);  write_cfg(1'b1, 0);     // R6 insert only
        wait_pos(5, 100);  write_cfg(1'b1, 300);   // R10 mixed
        wait_pos(6, WIN - 1); write_cfg(1'b1, 7);  // R7 boundary write
        wait_pos(8, 100);  write_cfg(1'b0, 0);     // R3 back to bypass
        wait_pos(10, 10);
        finish_run();
    end

endmodule